// File: doc/BRIEF.md
# Trace Entry FIFO With Loss Tagging

This block buffers trace entries produced by bus masters until a downstream packetiser drains them. Each entry carries a data word, a two-bit access size code, a one-bit region select and a flag telling whether the CPU or some other master made the access. The read side presents the oldest entry as packet fields together with a two-bit status code. The code is derived from the master flag, or replaced by a loss marker when entries were dropped.

The buffer never overwrites stored data. A write that arrives while every slot is occupied, and that is not paired with a read, is discarded. The discard sets a sticky loss flag. While the flag is set, the packet at the head of the buffer reports status 3. Reading that packet clears the flag, and later packets again report their master code. A read and a write issued together while the buffer is full are both accepted, because the read frees the slot that the write takes.

Top module: `trace_ovf_fifo`

## Requirements
- R1: After reset the buffer is empty (`empty`=1, `full`=0) and the loss flag is clear.
- R2: An accepted write stores data, size and region. Reads return entries in the order they were written, and the head entry appears on the read fields whenever `empty` is 0.
- R3: With the loss flag clear, `rd_status` is 0 when the head entry came from the CPU (`wr_cpu`=1) and 1 when it came from another master (`wr_cpu`=0).
- R4: `rd_status` never takes the reserved value 2.
- R5: A write while `full`=1 without `rd_en` is discarded. The stored entries and the head fields are unchanged, and `full` stays 1.
- R6: A discarded write sets the loss flag. From the next cycle on, `rd_status` reads 3 until the head packet is read.
- R7: Reading the packet that shows status 3 clears the loss flag. Only that one packet carries the loss code, and the following packet shows its master code.
- R8: `wr_en` and `rd_en` together while full accept both operations. `full` stays 1 and no loss is recorded.
- R9: `rd_en` while empty is ignored and the buffer stays empty.
- R10: `full` is 1 exactly when DEPTH entries are held, and `empty` is 1 exactly when none are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Trace data word |
| wr_size | input | 2 | Access size code (0:8, 1:16, 2:32, 3:64 bit) |
| wr_region | input | 1 | Region select |
| wr_cpu | input | 1 | 1 when the entry comes from the CPU |
| rd_en | input | 1 | Read request, pops the head entry |
| rd_data | output | DATA_W | Head entry data |
| rd_size | output | 2 | Head entry size code |
| rd_region | output | 1 | Head entry region |
| rd_status | output | 2 | 0 CPU, 1 other master, 3 entries lost |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No entry held |

## Verification
Two functions can land on the same edge. A write can arrive against a full buffer in the same cycle as a read, which must turn a would-be drop into an accepted write. A read can also consume the loss-tagged packet while further writes arrive. Directed phases fill the buffer, overfill it, and then issue paired reads and writes while it is full. A long random phase then mixes requests with a bias that keeps the buffer near full. A behavioural queue model with its own loss flag predicts `full`, `empty`, the head fields and the status on every clock, and the outputs are compared against it.

// File: rtl/trace_fifo_pkg.sv
package trace_fifo_pkg;
  localparam int unsigned SIZE_W = 2;
  localparam int unsigned STAT_W = 2;

  typedef enum logic [STAT_W-1:0] {
    ST_CPU   = 2'd0,
    ST_OTHER = 2'd1,
    ST_RSVD  = 2'd2,
    ST_LOST  = 2'd3
  } trc_status_e;
endpackage

// File: rtl/trace_fifo_ctrl.sv
module trace_fifo_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic          drop,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    full    = (cnt_q == CMAX);
    empty   = (cnt_q == '0);
    rd_fire = rd_req & ~empty;
    wr_fire = wr_req & (~full | rd_fire);
    drop    = wr_req & full & ~rd_fire;
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (wr_fire) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    if (rd_fire) rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    if (wr_fire && !rd_fire) cnt_d = cnt_q + 1'b1;
    else if (rd_fire && !wr_fire) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_fire) wr_ptr_q <= wr_ptr_d;
      if (rd_fire) rd_ptr_q <= rd_ptr_d;
      if (wr_fire ^ rd_fire) cnt_q <= cnt_d;
    end
  end

  assign wr_ptr = wr_ptr_q;
  assign rd_ptr = rd_ptr_q;

  // R10
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CMAX);
  // R5
  drop_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> full && $stable(rd_ptr_q) && $stable(wr_ptr_q));
  // R9
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty && !wr_req) |=> empty);
endmodule

// File: rtl/trace_fifo_store.sv
module trace_fifo_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned ENT_W = 68,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_ptr,
  input  logic [ENT_W-1:0] wr_ent,
  input  logic [AW-1:0]    rd_ptr,
  output logic [ENT_W-1:0] rd_ent
);
  logic [ENT_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_ptr == AW'(i));
    always_ff @(posedge clk) begin
      if (slot_we) mem[i] <= wr_ent;
    end
  end

  assign rd_ent = mem[rd_ptr];

  // R2
  slot_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_ptr)] == $past(wr_ent));
endmodule

// File: rtl/trace_fifo_ovf.sv
module trace_fifo_ovf
  import trace_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drop,
  input  logic              rd_fire,
  input  logic              head_cpu,
  output logic [STAT_W-1:0] status
);
  logic lost_q, lost_d;
  trc_status_e stat_e;

  always_comb begin
    lost_d = lost_q;
    if (rd_fire) lost_d = 1'b0;
    if (drop)    lost_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lost_q <= 1'b0;
    else if (rd_fire || drop)  lost_q <= lost_d;
  end

  always_comb begin
    if (lost_q)        stat_e = ST_LOST;
    else if (head_cpu) stat_e = ST_CPU;
    else               stat_e = ST_OTHER;
  end

  assign status = stat_e;

  // R4
  no_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status != ST_RSVD);
  // R6
  drop_tags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> status == ST_LOST);
  // R7
  tag_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_LOST && rd_fire && !drop) |=> status != ST_LOST);
endmodule

// File: rtl/trace_ovf_fifo.sv
module trace_ovf_fifo
  import trace_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic              wr_region,
  input  logic              wr_cpu,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [SIZE_W-1:0] rd_size,
  output logic              rd_region,
  output logic [STAT_W-1:0] rd_status,
  output logic              full,
  output logic              empty
);
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned ENT_W = DATA_W + SIZE_W + 2;
  localparam int unsigned CPU_B = ENT_W - 1;
  localparam int unsigned REG_B = ENT_W - 2;

  logic            wr_fire, rd_fire, drop, head_cpu;
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [ENT_W-1:0] wr_ent, rd_ent;

  assign wr_ent = {wr_cpu, wr_region, wr_size, wr_data};

  trace_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (wr_en),
    .rd_req  (rd_en),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire),
    .drop    (drop),
    .full    (full),
    .empty   (empty),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr)
  );

  trace_fifo_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_fire),
    .wr_ptr (wr_ptr),
    .wr_ent (wr_ent),
    .rd_ptr (rd_ptr),
    .rd_ent (rd_ent)
  );

  assign head_cpu = empty ? 1'b1 : rd_ent[CPU_B];

  trace_fifo_ovf u_ovf (
    .clk      (clk),
    .rst_n    (rst_n),
    .drop     (drop),
    .rd_fire  (rd_fire),
    .head_cpu (head_cpu),
    .status   (rd_status)
  );

  assign rd_data   = rd_ent[DATA_W-1:0];
  assign rd_size   = rd_ent[DATA_W +: SIZE_W];
  assign rd_region = rd_ent[REG_B];

  // R8
  paired_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && full) |=> full && rd_status != ST_LOST);
  // R1
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> empty);
endmodule

// File: tb/trace_ovf_fifo_tb.sv
`timescale 1ns/1ps
module trace_ovf_fifo_tb;
  localparam int DW = 64;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_region, wr_cpu, rd_en;
  logic [DW-1:0] wr_data;
  logic [1:0] wr_size;
  logic [DW-1:0] rd_data;
  logic [1:0] rd_size, rd_status;
  logic rd_region, full, empty;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  logic [DW+3:0] q[$];
  bit lost_m = 0, prev_lost = 0;
  bit last_drop = 0, last_pair = 0, last_idle_rd = 0;

  always #2.5 clk = ~clk;

  trace_ovf_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_size(wr_size), .wr_region(wr_region), .wr_cpu(wr_cpu),
    .rd_en(rd_en), .rd_data(rd_data), .rd_size(rd_size),
    .rd_region(rd_region), .rd_status(rd_status), .full(full), .empty(empty)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      finish_run();
    end
  end

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [DW+3:0] h;
    logic [1:0] es;
    chk("R10", "full", DW'(full), DW'(q.size() == DEPTH));
    chk("R10", "empty", DW'(empty), DW'(q.size() == 0));
    chk("R4", "status reserved", DW'(rd_status == 2'd2), '0);
    if (last_drop) chk("R5", "full after drop", DW'(full), 1);
    if (last_pair) chk("R8", "full after paired op", DW'(full), 1);
    if (last_idle_rd) chk("R9", "empty after idle read", DW'(empty), 1);
    if (q.size() != 0) begin
      h = q[0];
      chk("R2", "data", rd_data, h[DW-1:0]);
      chk("R2", "size", DW'(rd_size), DW'(h[DW+1:DW]));
      chk("R2", "region", DW'(rd_region), DW'(h[DW+2]));
      es = lost_m ? 2'd3 : (h[DW+3] ? 2'd0 : 2'd1);
      if (lost_m)         chk("R6", "status", DW'(rd_status), DW'(es));
      else if (prev_lost) chk("R7", "status", DW'(rd_status), DW'(es));
      else                chk("R3", "status", DW'(rd_status), DW'(es));
    end
  endtask

  task automatic cycle(bit we, bit re, bit cpu);
    logic [DW+3:0] e;
    bit fm, em, rf, wf, dr;
    wr_en = we; rd_en = re; wr_cpu = cpu;
    wr_data = {$urandom, $urandom};
    wr_size = 2'($urandom);
    wr_region = 1'($urandom);
    e = {wr_cpu, wr_region, wr_size, wr_data};
    fm = (q.size() == DEPTH);
    em = (q.size() == 0);
    rf = re && !em;
    wf = we && (!fm || rf);
    dr = we && fm && !re;
    last_drop = dr;
    last_pair = we && re && fm;
    last_idle_rd = re && em && !we;
    prev_lost = lost_m;
    if (rf) void'(q.pop_front());
    if (wf) q.push_back(e);
    lost_m = (lost_m && !rf) || dr;
    @(negedge clk);
    compare();
  endtask

  initial begin
    rst_n = 1'b0;
    wr_en = 0; rd_en = 0; wr_cpu = 0; wr_region = 0; wr_size = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "empty after reset", DW'(empty), 1);
    chk("R1", "full after reset", DW'(full), 0);
    compare();
    // fill with alternating masters
    for (int i = 0; i < DEPTH; i++) cycle(1, 0, i[0]);
    // overfill: drops
    for (int i = 0; i < 3; i++) cycle(1, 0, 1);
    // read tagged packet, then untagged ones
    for (int i = 0; i < 3; i++) cycle(0, 1, 0);
    for (int i = 0; i < 3; i++) cycle(1, 0, 0);
    // paired ops while full
    for (int i = 0; i < 4; i++) cycle(1, 1, i[0]);
    // overflow then paired op on the tagged packet
    cycle(1, 0, 1);
    cycle(1, 1, 0);
    cycle(0, 0, 0);
    // drain and read past empty
    for (int i = 0; i < DEPTH + 3; i++) cycle(0, 1, 0);
    // random near-full mix
    for (int i = 0; i < 3000; i++)
      cycle(($urandom % 10) < 6, ($urandom % 10) < 4, 1'($urandom));
    // random drain-heavy mix
    for (int i = 0; i < 2000; i++)
      cycle(($urandom % 10) < 4, ($urandom % 10) < 6, 1'($urandom));
    finish_run();
  end
endmodule